// File: doc/BRIEF.md
# USB Transmit Serializer with SYNC, Bit Stuffing, NRZI and EOP

This block is the transmit half of a USB transceiver's digital logic. It sits behind an 8-bit parallel port where a link controller offers bytes under a valid flag. The block acknowledges each byte as it captures it into a one-byte holding stage. It then sends the packet on the cable as a line-symbol stream. That stream holds a start pattern, the payload sent least significant bit first with zero-insertion after long runs of ones, NRZI coding, and an end-of-packet tail. A drive-enable flag goes with the stream, and everything advances only on a bit-rate strobe from the clock domain that owns the line timing.

A two-bit mode input is captured when a packet starts. It selects one of four behaviours: normal coding; a non-driving mode in which bytes are consumed but the line is never driven; a raw mode that sends bits directly, without stuffing or NRZI; and a reserved code that behaves exactly like normal. After reset, the block ignores the link for a fixed number of clock edges. A packet only starts on a fresh low-to-high transition of the valid flag.

Top module: `utx_serializer`

## Requirements
- R1: For the first five rising clock edges after reset release, tx_ready and drive_en stay low. A tx_valid that went high during that window and stayed high never starts a packet; only a later low-to-high transition of tx_valid does.
- R2: A rising tx_valid while idle starts a packet: tx_ready is high in that cycle, so the first byte is captured at that edge. From the next strobe on, the line carries the start pattern, which is seven zero bits and then a one bit. In normal mode, starting from idle J, this shows as K J K J K J K K. Line symbols on {line_p, line_m}: J = 2'b10, K = 2'b01, SE0 = 2'b00.
- R3: tx_ready is never high while tx_valid is low. Each acknowledged byte is sent exactly once, in order, least significant bit first. This holds even when bit_en is high on every cycle.
- R4: In normal mode, a one bit keeps the previous line level and a zero bit toggles it. The idle level is J.
- R5: In normal mode, after six consecutive one bits a zero is inserted, before NRZI coding. The final one of the start pattern counts towards the run. A stuffed zero is also inserted after the last payload bit, ahead of the end-of-packet tail.
- R6: When the last acknowledged byte has been sent and no further byte is held, the line shows SE0 for two strobes and then J for one strobe. drive_en then falls on the following strobe while the line stays at J. SE1 (2'b11) never appears, and SE0 appears only while drive_en is high.
- R7: op_mode 2'b10 (raw) sends each bit without stuffing or NRZI: a one is J and a zero is K. This applies to the start pattern too. The end-of-packet tail is unchanged.
- R8: op_mode 2'b01 (non-driving) still acknowledges every byte, but drive_en stays low for the whole packet and the line stays at J.
- R9: op_mode 2'b11 produces exactly the same line stream as op_mode 2'b00, with no error indication.
- R10: op_mode is captured at packet start. Changing it during a packet has no effect on that packet.
- R11: line_p, line_m and drive_en change only at clock edges where bit_en is high (reset excepted).
- R12: A low rst_n forces drive_en low, the line to J and tx_ready low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases on a clock edge |
| bit_en | input | 1 | Bit-rate strobe; one line symbol per high cycle |
| op_mode | input | 2 | 00 normal, 01 non-driving, 10 raw, 11 reserved (as normal) |
| tx_valid | input | 1 | Link holds a valid byte on tx_data; its rise starts a packet, its fall ends it |
| tx_data | input | 8 | Byte offered by the link |
| tx_ready | output | 1 | Byte on tx_data is captured at this clock edge |
| line_p | output | 1 | Positive line symbol bit |
| line_m | output | 1 | Negative line symbol bit |
| drive_en | output | 1 | Line driver enable |

## Verification
The hardest case to reach from the ports is the stuffed zero that must come after the final payload bit and before the SE0 tail. It only appears when a packet's last byte ends in exactly six ones, and the end-of-packet path has to insert it and not drop it. The stimulus sends a lone byte whose upper six bits are ones (0xFC). It also sends back-to-back 0xFF bytes, so runs cross byte boundaries and start from the start pattern's final one. The bench then compares the full captured symbol stream with a stream built from the coding rules. A second hard case is a tx_valid that is already high when the hold-off ends: it is raised right after reset release and held, to show that no packet starts.

// File: rtl/utx_pkg.sv
`timescale 1ns/1ps
// Shared types for the USB transmit serializer.
package utx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SYNC,
        TX_DATA,
        TX_EOP
    } tx_state_t;

    typedef enum logic [1:0] {
        SYM_BIT,
        SYM_SE0,
        SYM_J,
        SYM_REL
    } sym_kind_t;

    localparam logic [1:0] MODE_NORMAL  = 2'b00;
    localparam logic [1:0] MODE_NODRIVE = 2'b01;
    localparam logic [1:0] MODE_RAW     = 2'b10;
    localparam logic [1:0] MODE_RSVD    = 2'b11;

    typedef struct packed {
        logic raw;
        logic nodrive;
    } mode_cfg_t;

    // Reserved code decodes to plain normal behaviour.
    function automatic mode_cfg_t decode_mode(input logic [1:0] m);
        mode_cfg_t c;
        c.raw     = (m == MODE_RAW);
        c.nodrive = (m == MODE_NODRIVE);
        return c;
    endfunction

endpackage

// File: rtl/utx_holdoff.sv
`timescale 1ns/1ps
// Post-reset hold-off counter.
// Counts clock edges after reset release and raises armed once HOLD_EDGES
// edges have passed. Assumes rst_n release is aligned to clk.
module utx_holdoff #(
    parameter int HOLD_EDGES = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic armed
);
    localparam int CW = $clog2(HOLD_EDGES + 1);

    logic [CW-1:0] edge_cnt;

    // Saturating count of edges seen since reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            edge_cnt <= '0;
        else if (edge_cnt != CW'(HOLD_EDGES))
            edge_cnt <= edge_cnt + 1'b1;
    end

    assign armed = (edge_cnt == CW'(HOLD_EDGES));
endmodule

// File: rtl/utx_feed.sv
`timescale 1ns/1ps
// Byte feed: one-byte holding stage plus an LSB-first shift stage.
// The holding stage takes a byte on load_hold. The shift stage copies it on
// shift_load and moves one bit per shift_adv. Assumes load_hold is only
// requested while the holding stage is empty; shift_load wins over shift_adv.
module utx_feed #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hold,
    input  logic [DATA_W-1:0] din,
    input  logic              shift_load,
    input  logic              shift_adv,
    output logic              hold_full,
    output logic              cur_bit,
    output logic              last_bit
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] shift_q;
    logic [IW-1:0]     bit_idx;

    // Holding stage fill and drain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (load_hold) begin
            hold_q    <= din;
            hold_full <= 1'b1;
        end else if (shift_load) begin
            hold_full <= 1'b0;
        end
    end

    // Shift stage load and bit advance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            bit_idx <= '0;
        end else if (shift_load) begin
            shift_q <= hold_q;
            bit_idx <= '0;
        end else if (shift_adv) begin
            shift_q <= shift_q >> 1;
            bit_idx <= bit_idx + 1'b1;
        end
    end

    assign cur_bit  = shift_q[0];
    assign last_bit = (bit_idx == IW'(DATA_W - 1));
endmodule

// File: rtl/utx_linecoder.sv
`timescale 1ns/1ps
// Line coder: ones-run tracking for stuffing, NRZI level, registered line
// symbol and drive enable. Acts only when emit is high (one bit time).
// Assumes the sequencer emits a stuffed zero whenever stuff_pending is high.
module utx_linecoder #(
    parameter int STUFF_RUN = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                emit,
    input  utx_pkg::sym_kind_t  kind,
    input  logic                bit_in,
    input  logic                raw,
    input  logic                nodrive,
    output logic                stuff_pending,
    output logic                line_p,
    output logic                line_m,
    output logic                drive_en
);
    import utx_pkg::*;

    localparam int OW = $clog2(STUFF_RUN + 1);

    logic [OW-1:0] ones_q;
    logic          lvl_q;
    logic          lvl_next;
    logic          nx_p, nx_m, nx_drv;

    // Consecutive-ones count; cleared by zeros, raw bits and non-data symbols.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ones_q <= '0;
        else if (emit) begin
            if (kind == SYM_BIT && !raw && bit_in)
                ones_q <= ones_q + 1'b1;
            else
                ones_q <= '0;
        end
    end

    assign stuff_pending = !raw && (ones_q == OW'(STUFF_RUN));

    // Next line level: direct in raw mode, NRZI otherwise.
    always_comb begin
        if (raw)
            lvl_next = bit_in;
        else
            lvl_next = bit_in ? lvl_q : ~lvl_q;
    end

    // NRZI reference level tracking.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lvl_q <= 1'b1;
        else if (emit) begin
            case (kind)
                SYM_BIT: lvl_q <= lvl_next;
                SYM_SE0: lvl_q <= lvl_q;
                default: lvl_q <= 1'b1;
            endcase
        end
    end

    // Symbol selection for this bit time.
    always_comb begin
        nx_p   = 1'b1;
        nx_m   = 1'b0;
        nx_drv = 1'b1;
        case (kind)
            SYM_BIT: begin
                nx_p = lvl_next;
                nx_m = ~lvl_next;
            end
            SYM_SE0: begin
                nx_p = 1'b0;
                nx_m = 1'b0;
            end
            SYM_J: ;
            default: nx_drv = 1'b0;
        endcase
        if (nodrive) begin
            nx_p   = 1'b1;
            nx_m   = 1'b0;
            nx_drv = 1'b0;
        end
    end

    // Registered line outputs, updated once per bit time.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_p   <= 1'b1;
            line_m   <= 1'b0;
            drive_en <= 1'b0;
        end else if (emit) begin
            line_p   <= nx_p;
            line_m   <= nx_m;
            drive_en <= nx_drv;
        end
    end
endmodule

// File: rtl/utx_serializer.sv
`timescale 1ns/1ps
// USB transmit serializer top.
// Sequences start pattern, payload and end-of-packet tail; handshakes bytes
// with the link; captures the operating mode at packet start.
// Assumes tx_data stays valid while tx_valid is high and bit_en is a
// single-cycle strobe at the bit rate.
module utx_serializer #(
    parameter int DATA_W       = 8,
    parameter int HOLD_EDGES   = 5,
    parameter int STUFF_RUN    = 6,
    parameter int SYNC_BITS    = 8,
    parameter int EOP_SE0_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [1:0]        op_mode,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              line_p,
    output logic              line_m,
    output logic              drive_en
);
    import utx_pkg::*;

    localparam int EOP_STEPS = EOP_SE0_BITS + 2;
    localparam int CNT_MAX   = (SYNC_BITS > EOP_STEPS) ? SYNC_BITS : EOP_STEPS;
    localparam int CW        = $clog2(CNT_MAX);

    tx_state_t  state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    mode_cfg_t  mode_q;
    logic       valid_q;
    logic       armed;
    logic       start;
    logic       load_hold;
    logic       shift_load, shift_adv;
    logic       hold_full, cur_bit, last_bit;
    logic       emit, ebit, stuff_pending;
    logic       sync_last;
    sym_kind_t  kind;

    utx_holdoff #(.HOLD_EDGES(HOLD_EDGES)) u_holdoff (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed)
    );

    utx_feed #(.DATA_W(DATA_W)) u_feed (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_hold  (load_hold),
        .din        (tx_data),
        .shift_load (shift_load),
        .shift_adv  (shift_adv),
        .hold_full  (hold_full),
        .cur_bit    (cur_bit),
        .last_bit   (last_bit)
    );

    utx_linecoder #(.STUFF_RUN(STUFF_RUN)) u_coder (
        .clk           (clk),
        .rst_n         (rst_n),
        .emit          (emit),
        .kind          (kind),
        .bit_in        (ebit),
        .raw           (mode_q.raw),
        .nodrive       (mode_q.nodrive),
        .stuff_pending (stuff_pending),
        .line_p        (line_p),
        .line_m        (line_m),
        .drive_en      (drive_en)
    );

    assign start     = (state_q == TX_IDLE) && armed && tx_valid && !valid_q;
    assign load_hold = tx_valid && !hold_full &&
                       (start || state_q == TX_SYNC || state_q == TX_DATA);
    assign tx_ready  = load_hold;
    assign sync_last = (cnt_q == CW'(SYNC_BITS - 1));

    // Per-bit sequencing of start pattern, payload, stuffing and tail.
    always_comb begin
        state_n    = state_q;
        cnt_n      = cnt_q;
        shift_load = 1'b0;
        shift_adv  = 1'b0;
        emit       = 1'b0;
        kind       = SYM_BIT;
        ebit       = 1'b0;
        case (state_q)
            TX_IDLE: begin
                if (start) begin
                    state_n = TX_SYNC;
                    cnt_n   = '0;
                end
            end
            TX_SYNC: begin
                if (bit_en) begin
                    emit = 1'b1;
                    ebit = sync_last;
                    if (sync_last) begin
                        shift_load = 1'b1;
                        state_n    = TX_DATA;
                        cnt_n      = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            TX_DATA: begin
                if (bit_en) begin
                    emit = 1'b1;
                    if (!stuff_pending) begin
                        ebit      = cur_bit;
                        shift_adv = 1'b1;
                        if (last_bit) begin
                            if (hold_full) begin
                                shift_load = 1'b1;
                            end else begin
                                state_n = TX_EOP;
                                cnt_n   = '0;
                            end
                        end
                    end
                end
            end
            default: begin
                if (bit_en) begin
                    emit = 1'b1;
                    if (cnt_q == '0 && stuff_pending) begin
                        kind = SYM_BIT;
                    end else if (cnt_q < CW'(EOP_SE0_BITS)) begin
                        kind  = SYM_SE0;
                        cnt_n = cnt_q + 1'b1;
                    end else if (cnt_q == CW'(EOP_SE0_BITS)) begin
                        kind  = SYM_J;
                        cnt_n = cnt_q + 1'b1;
                    end else begin
                        kind    = SYM_REL;
                        state_n = TX_IDLE;
                        cnt_n   = '0;
                    end
                end
            end
        endcase
    end

    // Sequencer state and step counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Mode capture at packet start and tx_valid edge history.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= tx_valid;
            if (start)
                mode_q <= decode_mode(op_mode);
        end
    end
endmodule

// File: rtl/utx_serializer_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for utx_serializer, attached by bind.
module utx_serializer_chk #(
    parameter int HOLD_EDGES = 5
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic tx_valid,
    input logic tx_ready,
    input logic line_p,
    input logic line_m,
    input logic drive_en
);
    localparam int CW = $clog2(HOLD_EDGES + 1);

    logic [CW-1:0] since_rst;

    // Edges seen since reset release, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != CW'(HOLD_EDGES))
            since_rst <= since_rst + 1'b1;
    end

    AST_HOLDOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != CW'(HOLD_EDGES)) |-> (!tx_ready && !drive_en)); // R1

    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |-> !tx_ready); // R3

    AST_NO_SE1: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_p && line_m)); // R6

    AST_SE0_ONLY_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_p && !line_m) |-> drive_en); // R6

    AST_RELEASE_AT_J: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_en) |-> (line_p && !line_m)); // R6

    AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable({line_p, line_m, drive_en})); // R11
endmodule

bind utx_serializer utx_serializer_chk #(.HOLD_EDGES(HOLD_EDGES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .line_p   (line_p),
    .line_m   (line_m),
    .drive_en (drive_en)
);

// File: tb/utx_serializer_bench.sv
`timescale 1ns/1ps
module utx_serializer_bench;

    localparam logic [1:0] SJ = 2'b10, SK = 2'b01, S0 = 2'b00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [1:0] op_mode = 2'b00;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready, line_p, line_m, drive_en;

    int checks = 0;
    int fails = 0;
    logic [7:0] pkt [0:15];
    int pkt_n = 0;
    logic [1:0] expv [0:511];
    int exp_n = 0;
    logic [1:0] cap [0:511];
    int cap_n = 0;
    int bit_div = 4;
    int div_cnt = 0;
    logic strobe_d = 1'b0;
    int acks = 0;
    int glitch = 0;
    logic saw_drive = 1'b0;
    logic [2:0] prev_out = 3'b100;
    logic prev_ok = 1'b0;
    logic e_lvl;
    int e_ones;

    always #2.5 clk = ~clk;

    utx_serializer u_utx_serializer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .op_mode(op_mode),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .line_p(line_p), .line_m(line_m), .drive_en(drive_en)
    );

    // Bit strobe generator.
    always @(negedge clk) begin
        bit_en = (div_cnt == 0);
        div_cnt = (div_cnt + 1) % bit_div;
    end

    always @(posedge clk) strobe_d <= bit_en;

    // Line monitor: capture, drive tracking and between-strobe changes.
    always @(negedge clk) begin
        if (rst_n && prev_ok && !strobe_d && ({line_p, line_m, drive_en} != prev_out))
            glitch++;
        prev_out = {line_p, line_m, drive_en};
        prev_ok = rst_n;
        if (drive_en) saw_drive = 1'b1;
        if (strobe_d && drive_en && cap_n < 512) begin
            cap[cap_n] = {line_p, line_m};
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expd);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expd);
        end
    endtask

    task automatic push(input logic [1:0] s);
        expv[exp_n] = s;
        exp_n++;
    endtask

    task automatic emitb(input bit b, input bit raw);
        if (raw) push(b ? SJ : SK);
        else begin
            if (!b) e_lvl = ~e_lvl;
            push(e_lvl ? SJ : SK);
            e_ones = b ? e_ones + 1 : 0;
            if (e_ones == 6) begin
                e_lvl = ~e_lvl;
                push(e_lvl ? SJ : SK);
                e_ones = 0;
            end
        end
    endtask

    // Expected symbol stream from the coding rules.
    task automatic build_exp(input bit raw);
        exp_n = 0;
        e_lvl = 1'b1;
        e_ones = 0;
        for (int i = 0; i < 8; i++) emitb(i == 7, raw);
        for (int b = 0; b < pkt_n; b++)
            for (int k = 0; k < 8; k++) emitb(pkt[b][k], raw);
        push(S0); push(S0); push(SJ);
    endtask

    task automatic cmp(input string req);
        int mism = 0;
        chk(cap_n == exp_n, req, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (cap[i] != expv[i]) mism++;
        chk(mism == 0, req, mism, 0);
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        tx_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic send_pkt(input logic [1:0] mode, input bit flip, input logic [1:0] flip_to);
        int i = 0;
        op_mode = mode;
        cap_n = 0;
        acks = 0;
        saw_drive = 1'b0;
        @(posedge clk);
        #1;
        tx_data = pkt[0];
        tx_valid = 1'b1;
        while (i < pkt_n) begin
            @(negedge clk);
            if (tx_ready) begin
                i++;
                acks++;
                @(posedge clk);
                #1;
                if (flip) op_mode = flip_to;
                if (i < pkt_n) tx_data = pkt[i];
                else tx_valid = 1'b0;
            end
        end
        for (int w = 0; w < 1500; w++) begin
            @(negedge clk);
            if (saw_drive && !drive_en) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        reset_dut();
        @(negedge clk);
        chk(line_p && !line_m, "R12 idle line J", {30'd0, line_p, line_m}, 2);
        chk(!drive_en && !tx_ready, "R12 idle drive/ready", {30'd0, drive_en, tx_ready}, 0);
    endtask

    task automatic t_holdoff();
        int rdy = 0;
        reset_dut();
        tx_data = 8'h5A;
        tx_valid = 1'b1;
        saw_drive = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (tx_ready) rdy++;
        end
        chk(rdy == 0, "R1 no ack for held tx_valid", rdy, 0);
        chk(!saw_drive, "R1 no drive for held tx_valid", saw_drive, 0);
        tx_valid = 1'b0;
        repeat (3) @(negedge clk);
        pkt[0] = 8'h5A; pkt_n = 1;
        build_exp(1'b0);
        send_pkt(2'b00, 1'b0, 2'b00);
        cmp("R1 later rise starts packet");
    endtask

    task automatic t_basic();
        int sm = 0;
        logic [1:0] sp [0:7];
        sp[0] = SK; sp[1] = SJ; sp[2] = SK; sp[3] = SJ;
        sp[4] = SK; sp[5] = SJ; sp[6] = SK; sp[7] = SK;
        pkt[0] = 8'hA5; pkt[1] = 8'h3C; pkt[2] = 8'h01; pkt_n = 3;
        build_exp(1'b0);
        send_pkt(2'b00, 1'b0, 2'b00);
        for (int i = 0; i < 8; i++) if (cap[i] != sp[i]) sm++;
        chk(sm == 0, "R2 start pattern", sm, 0);
        chk(acks == 3, "R3 one ack per byte", acks, 3);
        cmp("R4 R6 NRZI stream and tail");
    endtask

    task automatic t_stuff();
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt_n = 2;
        build_exp(1'b0);
        send_pkt(2'b00, 1'b0, 2'b00);
        cmp("R5 stuffing across bytes");
        pkt[0] = 8'hFC; pkt_n = 1;
        build_exp(1'b0);
        send_pkt(2'b00, 1'b0, 2'b00);
        cmp("R5 stuff before tail");
    endtask

    task automatic t_raw();
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h00; pkt[3] = 8'h81; pkt_n = 4;
        build_exp(1'b1);
        send_pkt(2'b10, 1'b0, 2'b10);
        cmp("R7 raw stream");
    endtask

    task automatic t_nodrive();
        pkt[0] = 8'h12; pkt[1] = 8'h34; pkt_n = 2;
        send_pkt(2'b01, 1'b0, 2'b01);
        chk(acks == 2, "R8 bytes acknowledged", acks, 2);
        chk(!saw_drive, "R8 never driven", saw_drive, 0);
        chk(line_p && !line_m, "R8 line at J", {30'd0, line_p, line_m}, 2);
    endtask

    task automatic t_reserved();
        pkt[0] = 8'hFF; pkt[1] = 8'h7E; pkt_n = 2;
        build_exp(1'b0);
        send_pkt(2'b11, 1'b0, 2'b11);
        cmp("R9 reserved equals normal");
    endtask

    task automatic t_latch();
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h0F; pkt_n = 3;
        build_exp(1'b1);
        send_pkt(2'b10, 1'b1, 2'b00);
        cmp("R10 mode held for packet");
    endtask

    task automatic t_fast();
        bit_div = 1;
        pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h33; pkt[3] = 8'hF7; pkt_n = 4;
        build_exp(1'b0);
        send_pkt(2'b00, 1'b0, 2'b00);
        chk(acks == 4, "R3 acks at full strobe rate", acks, 4);
        cmp("R3 order at full strobe rate");
        bit_div = 3;
    endtask

    task automatic t_async_reset();
        op_mode = 2'b00;
        @(posedge clk);
        #1 tx_data = 8'h00; tx_valid = 1'b1;
        for (int w = 0; w < 300; w++) begin
            @(negedge clk);
            if (drive_en) break;
        end
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        chk(!drive_en, "R12 drive drops at reset", drive_en, 0);
        chk(line_p && !line_m, "R12 line J at reset", {30'd0, line_p, line_m}, 2);
        chk(!tx_ready, "R12 ready low at reset", tx_ready, 0);
        tx_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_holdoff();
        t_basic();
        t_stuff();
        t_raw();
        t_nodrive();
        t_reserved();
        t_latch();
        t_fast();
        t_async_reset();
        chk(glitch == 0, "R11 outputs change only on strobe", glitch, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule